// File: doc/BRIEF.md
# Paired Channel Repeater Crossbar

This block chooses what each of six channel transmitters sends, one 10-bit code group per word slot. The channels are indexed 0 to 5 and form fixed pairs: 0 with 1, 2 with 3, and 4 with 5. When a channel's repeat-enable bit is set, the words it receives are sent out on its partner's transmitter. When the bit is clear, the partner transmitter sends its own local parallel word.

Each channel also has a path-select bit, which picks one of two repeat paths. The direct path forwards the received word unchanged, with no rate compensation. The retimed path first stores the received words in a small per-channel compensation FIFO, then sends them one per local word slot. If that FIFO is empty, the retimed path sends an idle code group instead.

Both bit sets sit in a small register bank, written through an address/data/write-enable port. The transmit outputs change only on word-slot strobes. A configuration change therefore never splits a code group.

Top module: `rpt_xbar`

## Requirements
- R1: While reset is asserted and afterwards until the first word strobe, every transmit word equals the idle code 10'h0FA, and all enable and path bits read as zero.
- R2: A write with address 0 loads the six repeat-enable bits, and a write with address 1 loads the six path-select bits. Bit i belongs to channel i. A path bit of 0 selects the direct path, and 1 selects the retimed path. A write takes effect from the next clock on.
- R3: On a word strobe, if the partner's enable bit is clear, transmitter c loads its own parallel word tx_par_i[c].
- R4: The partner of channel c is channel c XOR 1. On a word strobe, if the partner's enable bit is set and its path bit is 0, transmitter c loads the partner's rx_word_i from that same cycle.
- R5: If the partner's enable and path bits are both set, transmitter c sends the partner's FIFO contents in arrival order, one word per strobe. A word is written to a channel's FIFO in each cycle its rx_vld_i bit is high.
- R6: On the retimed path, a strobe that finds the partner's FIFO empty sends the idle code 10'h0FA.
- R7: In cycles without a word strobe, every transmit word holds its value.
- R8: Each FIFO stores up to 4 words. A word that arrives while 4 words are stored, and no strobe removes one in the same cycle, is dropped, and the stored words are unchanged.
- R9: Each FIFO gives up its oldest word on every strobe, whatever the enable and path bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0: enable bits, 1: path bits |
| wr_data_i | input | 6 | Write data, bit i for channel i |
| word_stb_i | input | 1 | Word-slot boundary strobe |
| rx_word_i | input | 60 | Received words, channel i at bits [10i+9:10i] |
| rx_vld_i | input | 6 | Received word valid per channel |
| tx_par_i | input | 60 | Local parallel transmit words, same packing |
| tx_word_o | output | 60 | Transmit words, same packing |

## Verification
The bench first runs directed sequences. One keeps the enables clear to show local words pass through. One overfills a retimed FIFO, which separates word dropping from overwriting and shows the idle code once the FIFO drains. One fills a FIFO while its enable is clear, which shows that draining does not depend on the enable. After that comes random stimulus in which enables, path bits, valids and strobes change almost every cycle. That run separates the pair mapping (c XOR 1 against any other partner) and the direct path from the retimed path. Cycles without a strobe show whether outputs are updated only at word boundaries.

// File: rtl/rpt_pkg.sv
package rpt_pkg;
  typedef enum logic {ADDR_EN = 1'b0, ADDR_MODE = 1'b1} cfg_addr_e;
  typedef enum logic {PATH_DIRECT = 1'b0, PATH_RETIME = 1'b1} path_e;
endpackage

// File: rtl/rpt_regs.sv
module rpt_regs
  import rpt_pkg::*;
#(
  parameter int NCH = 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  logic           wr_addr_i,
  input  logic [NCH-1:0] wr_data_i,
  output logic [NCH-1:0] en_o,
  output logic [NCH-1:0] mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= '0;
      mode_o <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == ADDR_MODE) mode_o <= wr_data_i;
      else                        en_o   <= wr_data_i;
    end
  end

  assert_wr_en_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == ADDR_EN) |=> en_o == $past(wr_data_i));
  assert_wr_mode_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == ADDR_MODE) |=> mode_o == $past(wr_data_i));
endmodule

// File: rtl/rpt_fifo.sv
module rpt_fifo #(
  parameter int          W     = 10,
  parameter int          DEPTH = 4,
  parameter logic [W-1:0] IDLE = 10'h0FA
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          pop_ok, push_ok;

  assign pop_ok  = pop_i && (cnt_q != '0);
  assign push_ok = push_i && ((cnt_q != CW'(DEPTH)) || pop_ok);
  assign head_o  = (cnt_q == '0) ? IDLE : mem_q[rd_ptr_q];

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= inc(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= inc(rd_ptr_q);
      if (push_ok && !pop_ok)      cnt_q <= cnt_q + 1'b1;
      else if (pop_ok && !push_ok) cnt_q <= cnt_q - 1'b1;
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  assert_drop_full_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && cnt_q == CW'(DEPTH) && !pop_i) |=> (cnt_q == CW'(DEPTH)) && $stable(wr_ptr_q));
  assert_drain_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/rpt_xbar.sv
module rpt_xbar
  import rpt_pkg::*;
#(
  parameter int           NCH   = 6,
  parameter int           W     = 10,
  parameter int           DEPTH = 4,
  parameter logic [W-1:0] IDLE  = 10'h0FA
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_addr_i,
  input  logic [NCH-1:0]   wr_data_i,
  input  logic             word_stb_i,
  input  logic [NCH*W-1:0] rx_word_i,
  input  logic [NCH-1:0]   rx_vld_i,
  input  logic [NCH*W-1:0] tx_par_i,
  output logic [NCH*W-1:0] tx_word_o
);
  logic [NCH-1:0] en_q, mode_q;
  logic [W-1:0]   head_w [NCH];

  rpt_regs #(.NCH(NCH)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .en_o(en_q), .mode_o(mode_q)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_fifo
    rpt_fifo #(.W(W), .DEPTH(DEPTH), .IDLE(IDLE)) u_fifo (
      .clk_i, .rst_ni,
      .push_i(rx_vld_i[c]),
      .data_i(rx_word_i[c*W +: W]),
      .pop_i (word_stb_i),
      .head_o(head_w[c])
    );
  end

  for (genvar c = 0; c < NCH; c++) begin : g_tx
    localparam int P = c ^ 1;  // fixed adjacent pairing
    logic [W-1:0] nxt;

    always_comb begin
      if (!en_q[P])                    nxt = tx_par_i[c*W +: W];
      else if (mode_q[P] == PATH_RETIME) nxt = head_w[P];
      else                             nxt = rx_word_i[P*W +: W];
    end

    // update only at word boundaries so no partial group is sent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         tx_word_o[c*W +: W] <= IDLE;
      else if (word_stb_i) tx_word_o[c*W +: W] <= nxt;
    end

    assert_bypass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (word_stb_i && !en_q[P]) |=> tx_word_o[c*W +: W] == $past(tx_par_i[c*W +: W]));
    assert_direct_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (word_stb_i && en_q[P] && !mode_q[P]) |=> tx_word_o[c*W +: W] == $past(rx_word_i[P*W +: W]));
    assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !word_stb_i |=> $stable(tx_word_o[c*W +: W]));
  end
endmodule

// File: tb/tb_rpt_xbar.sv
module tb_rpt_xbar;
  localparam int NCH = 6, W = 10, DEPTH = 4;
  localparam logic [W-1:0] IDLE = 10'h0FA;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en, wr_addr, stb;
  logic [NCH-1:0] wr_data, rx_vld;
  logic [NCH*W-1:0] rx_word, tx_par, tx_word;

  rpt_xbar dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .word_stb_i(stb), .rx_word_i(rx_word),
    .rx_vld_i(rx_vld), .tx_par_i(tx_par), .tx_word_o(tx_word)
  );

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0, errors = 0;
  string phase = "reset";
  logic [NCH-1:0] m_en = '0, m_mode = '0;
  logic [W-1:0] m_q [NCH][DEPTH];
  int m_cnt [NCH];
  logic [W-1:0] m_tx [NCH];
  string m_tag [NCH];

  task automatic chk(string tag, int ch, logic [W-1:0] got, logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s (%s) ch%0d got %h exp %h", tag, phase, ch, got, exp);
    end
  endtask

  task automatic clear_in();
    wr_en = 0; wr_addr = 0; wr_data = '0; stb = 0; rx_vld = '0;
  endtask

  // inputs already driven; model the next edge, then compare
  task automatic step();
    for (int c = 0; c < NCH; c++) begin
      int p = c ^ 1;
      if (!stb) m_tag[c] = "R7";
      else if (!m_en[p]) begin m_tx[c] = tx_par[c*W +: W]; m_tag[c] = "R3"; end
      else if (!m_mode[p]) begin m_tx[c] = rx_word[p*W +: W]; m_tag[c] = "R4"; end
      else if (m_cnt[p] > 0) begin m_tx[c] = m_q[p][0]; m_tag[c] = "R5"; end
      else begin m_tx[c] = IDLE; m_tag[c] = "R6"; end
    end
    for (int c = 0; c < NCH; c++) begin
      if (stb && m_cnt[c] > 0) begin  // R9 drain on every strobe
        for (int k = 0; k < DEPTH - 1; k++) m_q[c][k] = m_q[c][k+1];
        m_cnt[c]--;
      end
      if (rx_vld[c] && m_cnt[c] < DEPTH) begin
        m_q[c][m_cnt[c]] = rx_word[c*W +: W];
        m_cnt[c]++;
      end
    end
    if (wr_en) begin  // R2: address 0 enables, 1 path bits
      if (wr_addr) m_mode = wr_data; else m_en = wr_data;
    end
    @(posedge clk); #1;
    for (int c = 0; c < NCH; c++) chk(m_tag[c], c, tx_word[c*W +: W], m_tx[c]);
    @(negedge clk);
  endtask

  task automatic wr(logic a, logic [NCH-1:0] d);
    clear_in(); wr_en = 1; wr_addr = a; wr_data = d;
    step(); clear_in();
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    clear_in(); rx_word = '0; tx_par = '0;
    for (int c = 0; c < NCH; c++) begin m_cnt[c] = 0; m_tx[c] = IDLE; end
    repeat (3) @(posedge clk);
    #1;
    for (int c = 0; c < NCH; c++) chk("R1", c, tx_word[c*W +: W], IDLE);
    @(negedge clk); rst_n = 1;
    step();  // still idle, no strobe (R1)

    // R3: enables clear, local words pass
    phase = "R3 local";
    for (int i = 0; i < 4; i++) begin
      tx_par = {$urandom, $urandom}; stb = 1; step();
    end
    clear_in();

    // R8: overfill FIFO of channel 0, retimed onto channel 1
    phase = "R8 overfill";
    wr(1'b0, 6'b000001); wr(1'b1, 6'b000001);
    for (int i = 0; i < 6; i++) begin
      rx_word[0 +: W] = W'(10'h100 + i); rx_vld = 6'b000001; step();
    end
    clear_in();
    for (int i = 0; i < 5; i++) begin
      stb = 1; step();
      if (i == 3) chk("R8", 1, tx_word[W +: W], 10'h103);
      if (i == 4) chk("R6", 1, tx_word[W +: W], IDLE);
    end
    clear_in();

    // R9: channel 2 FIFO drains while disabled
    phase = "R9 drain";
    wr(1'b0, 6'b000000); wr(1'b1, 6'b000100);
    for (int i = 0; i < 3; i++) begin
      rx_word[2*W +: W] = W'(10'h200 + i); rx_vld = 6'b000100; step();
    end
    clear_in();
    for (int i = 0; i < 3; i++) begin stb = 1; step(); end
    clear_in();
    wr(1'b0, 6'b000100);
    stb = 1; step();
    chk("R9", 3, tx_word[3*W +: W], IDLE);
    clear_in();

    // random mix
    phase = "random";
    for (int i = 0; i < 4000; i++) begin
      clear_in();
      rx_word = {$urandom, $urandom};
      tx_par  = {$urandom, $urandom};
      rx_vld  = NCH'($urandom);
      stb     = ($urandom % 3) != 0;
      if ($urandom % 8 == 0) begin
        wr_en = 1; wr_addr = 1'($urandom); wr_data = NCH'($urandom);
      end
      step();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule